// File: doc/BRIEF.md
# Router Bus Bypass and Pause Unit

This unit sits at the switch stage of a virtual-channel mesh router. It lets the router act as a pass-through node on a shared bus that is built from the router's own point-to-point links. An external bus arbiter drives a pause level and a two-bit direction code. While the pause level is high, the unit connects one mesh input straight to the opposite mesh output. The flit arriving on that link skips the input buffer and goes to the crossbar, and the switch allocator loses that output port for as long as the bus holds it.

Normal wormhole packets that need the claimed input or output are frozen in their buffers. The unit keeps the output-ownership state of every link in its own register and copies it to a save register when the bus takes the link. When the bus lets go, it restores the saved state, so an interrupted packet continues on the same output without a new allocation. The unit also counts the bus operations it has served back to back while local flits are waiting. After four of them it raises a starvation token toward the arbiter.

Top module: `bus_bypass_unit`

## Requirements
- R1: Port indices are north 0, south 1, west 2, east 3, and local 4 and above. Direction codes are 0 north-to-south, 1 south-to-north, 2 west-to-east and 3 east-to-west. While `pause_i` is high, on the next clock the output opposite the source port shows `xb_vld_o` equal to the source port's `link_valid_i` and `xb_sel_o` equal to the source index. The source port's `xb_flit_o` lane carries its `link_flit_i` instead of its buffered flit.
- R2: With no pause and no ownership held, an output granted by `sa_gnt_i`/`sa_sel_i` is used only when the selected buffered flit is a head flit (bit FW-1 set; bit FW-2 marks a tail). That input's `buf_pop_o` is high in the same cycle. On the next clock, `xb_vld_o` is high, `xb_sel_o` equals the granted input and that input's lane carries the buffered flit.
- R3: While paused, an allocator grant to the claimed output is ignored. The claimed input's buffer is not popped.
- R4: While paused, ports not claimed by the bus keep forwarding normal traffic.
- R5: After a head flit without a tail bit is forwarded, later flits from that input continue on the same output without any allocator grant, until a tail flit passes.
- R6: A packet interrupted by a pause resumes on the same output from the same input afterwards. Its flits appear once each and in order.
- R7: In the cycle after pause falls, the previously claimed output and input stay idle. The saved ownership is back in force from the following cycle.
- R8: When four pause operations have started with no normal forward between them and buffered flits are waiting, `starve_o` goes high on the clock that samples the fourth start.
- R9: The starvation count clears when any normal flit is forwarded or when no buffer holds a flit. `starve_o` is then low.
- R10: After reset, `xb_vld_o`, `buf_pop_o` and `starve_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pause_i | input | 1 | Bus claims a link through this node |
| dir_i | input | 2 | Bus direction code |
| link_valid_i | input | P | Per-port incoming link flit valid |
| link_flit_i | input | P*FW | Per-port incoming link flit |
| buf_valid_i | input | P | Per-port input buffer holds a flit |
| buf_flit_i | input | P*FW | Per-port input buffer head flit |
| sa_gnt_i | input | P | Per-output switch allocator grant |
| sa_sel_i | input | P*IW | Per-output granted input index |
| buf_pop_o | output | P | Per-input buffer read this cycle |
| xb_vld_o | output | P | Per-output crossbar valid (registered) |
| xb_sel_o | output | P*IW | Per-output crossbar input select (registered) |
| xb_flit_o | output | P*FW | Per-input crossbar lane flit (registered) |
| starve_o | output | 1 | Starvation token toward the arbiter |

## Verification
The hardest case to reach is a bus claim that lands in the middle of a wormhole packet, between its head and its tail. The claim must then be released and the body must resume with no new grant. The stimulus drives a four-flit packet from a small buffer model that advances only on `buf_pop_o`. It grants the output once, then raises pause on the same output after the first body flit. The output is logged cycle by cycle through the pause, the idle release cycle and the resumed tail.

// File: rtl/bbu_pkg.sv
package bbu_pkg;
  typedef enum logic [1:0] {
    DIR_N2S = 2'd0,
    DIR_S2N = 2'd1,
    DIR_W2E = 2'd2,
    DIR_E2W = 2'd3
  } bdir_e;

  localparam int PORT_N = 0;
  localparam int PORT_S = 1;
  localparam int PORT_W = 2;
  localparam int PORT_E = 3;

  function automatic int src_port(bdir_e d);
    case (d)
      DIR_N2S: return PORT_N;
      DIR_S2N: return PORT_S;
      DIR_W2E: return PORT_W;
      default: return PORT_E;
    endcase
  endfunction

  function automatic int dst_port(bdir_e d);
    case (d)
      DIR_N2S: return PORT_S;
      DIR_S2N: return PORT_N;
      DIR_W2E: return PORT_E;
      default: return PORT_W;
    endcase
  endfunction
endpackage

// File: rtl/bbu_dir_decode.sv
module bbu_dir_decode
  import bbu_pkg::*;
#(
  parameter int P = 5
) (
  input  logic         en,
  input  logic [1:0]   dir,
  output logic [P-1:0] in_mask,
  output logic [P-1:0] out_mask
);
  for (genvar p = 0; p < P; p++) begin : g_port
    assign in_mask[p]  = en && (p == src_port(bdir_e'(dir)));
    assign out_mask[p] = en && (p == dst_port(bdir_e'(dir)));
  end
endmodule

// File: rtl/bbu_link_state.sv
module bbu_link_state #(
  parameter int P  = 5,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [P-1:0]  start_mask,
  input  logic [P-1:0]  rel_mask,
  input  logic [P-1:0]  fwd,
  input  logic [P*IW-1:0] fwd_src,
  input  logic [P-1:0]  fwd_head,
  input  logic [P-1:0]  fwd_tail,
  output logic [P-1:0]  own_vld,
  output logic [P*IW-1:0] own_src
);
  for (genvar o = 0; o < P; o++) begin : g_link
    logic          lk_v;
    logic [IW-1:0] lk_s;
    logic          sv_v;
    logic [IW-1:0] sv_s;

    always_ff @(posedge clk) begin
      if (rst) begin
        lk_v <= 1'b0;
        lk_s <= '0;
        sv_v <= 1'b0;
        sv_s <= '0;
      end else if (start_mask[o]) begin
        sv_v <= lk_v;
        sv_s <= lk_s;
        lk_v <= 1'b0;
      end else if (rel_mask[o]) begin
        lk_v <= sv_v;
        lk_s <= sv_s;
        sv_v <= 1'b0;
      end else if (fwd[o]) begin
        if (fwd_head[o] && !fwd_tail[o]) begin
          lk_v <= 1'b1;
          lk_s <= fwd_src[o*IW +: IW];
        end else if (fwd_tail[o]) begin
          lk_v <= 1'b0;
        end
      end
    end

    assign own_vld[o]            = lk_v;
    assign own_src[o*IW +: IW]   = lk_s;
  end
endmodule

// File: rtl/bbu_starve.sv
module bbu_starve #(
  parameter int N  = 4,
  parameter int CW = $clog2(N + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic op_start,
  input  logic fwd_any,
  input  logic wait_any,
  output logic starve_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (fwd_any || !wait_any) cnt_n = '0;
    else if (op_start && (cnt_q < CW'(N))) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      starve_o <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      starve_o <= (cnt_n >= CW'(N)) && wait_any;
    end
  end
endmodule

// File: rtl/bus_bypass_unit.sv
module bus_bypass_unit
  import bbu_pkg::*;
#(
  parameter int P        = 5,
  parameter int FW       = 16,
  parameter int STARVE_N = 4,
  parameter int IW       = $clog2(P)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pause_i,
  input  logic [1:0]      dir_i,
  input  logic [P-1:0]    link_valid_i,
  input  logic [P*FW-1:0] link_flit_i,
  input  logic [P-1:0]    buf_valid_i,
  input  logic [P*FW-1:0] buf_flit_i,
  input  logic [P-1:0]    sa_gnt_i,
  input  logic [P*IW-1:0] sa_sel_i,
  output logic [P-1:0]    buf_pop_o,
  output logic [P-1:0]    xb_vld_o,
  output logic [P*IW-1:0] xb_sel_o,
  output logic [P*FW-1:0] xb_flit_o,
  output logic            starve_o
);
  localparam int HEAD_B = FW - 1;
  localparam int TAIL_B = FW - 2;

  logic          pause_q;
  logic [1:0]    dir_q;
  logic          release_c;
  logic [1:0]    blk_dir;
  logic [P-1:0]  bus_in, bus_out, blk_in, blk_out;
  logic [IW-1:0] bus_src;
  logic [P-1:0]  own_vld;
  logic [P*IW-1:0] own_src;
  logic [P*IW-1:0] cand;
  logic [P-1:0]  fwd, fwd_head, fwd_tail;

  assign release_c = pause_q && !pause_i;
  assign blk_dir   = pause_i ? dir_i : dir_q;
  assign bus_src   = IW'(src_port(bdir_e'(dir_i)));

  always_ff @(posedge clk) begin
    if (rst) begin
      pause_q <= 1'b0;
      dir_q   <= '0;
    end else begin
      pause_q <= pause_i;
      if (pause_i) dir_q <= dir_i;
    end
  end

  bbu_dir_decode #(.P(P)) u_bus_map (
    .en(pause_i), .dir(dir_i), .in_mask(bus_in), .out_mask(bus_out)
  );

  bbu_dir_decode #(.P(P)) u_blk_map (
    .en(pause_i || release_c), .dir(blk_dir), .in_mask(blk_in), .out_mask(blk_out)
  );

  for (genvar o = 0; o < P; o++) begin : g_out
    logic [IW-1:0] c;
    logic [FW-1:0] cf;
    logic          in_rng;
    assign c      = own_vld[o] ? own_src[o*IW +: IW] : sa_sel_i[o*IW +: IW];
    assign in_rng = (int'(c) < P);
    assign cf     = in_rng ? buf_flit_i[c*FW +: FW] : '0;
    assign cand[o*IW +: IW] = c;
    assign fwd[o] = in_rng && !blk_out[o]
                    && (own_vld[o] || (sa_gnt_i[o] && cf[HEAD_B]))
                    && buf_valid_i[c] && !blk_in[c];
    assign fwd_head[o] = cf[HEAD_B];
    assign fwd_tail[o] = cf[TAIL_B];
  end

  always_comb begin
    buf_pop_o = '0;
    for (int o = 0; o < P; o++)
      if (fwd[o]) buf_pop_o[cand[o*IW +: IW]] = 1'b1;
  end

  bbu_link_state #(.P(P), .IW(IW)) u_links (
    .clk(clk), .rst(rst),
    .start_mask(bus_out & {P{!pause_q}}),
    .rel_mask(blk_out & {P{release_c}}),
    .fwd(fwd), .fwd_src(cand), .fwd_head(fwd_head), .fwd_tail(fwd_tail),
    .own_vld(own_vld), .own_src(own_src)
  );

  bbu_starve #(.N(STARVE_N)) u_starve (
    .clk(clk), .rst(rst),
    .op_start(pause_i && !pause_q),
    .fwd_any(|fwd),
    .wait_any(|buf_valid_i),
    .starve_o(starve_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      xb_vld_o  <= '0;
      xb_sel_o  <= '0;
      xb_flit_o <= '0;
    end else begin
      for (int o = 0; o < P; o++) begin
        if (bus_out[o]) begin
          xb_vld_o[o]              <= link_valid_i[bus_src];
          xb_sel_o[o*IW +: IW]     <= bus_src;
        end else begin
          xb_vld_o[o]              <= fwd[o];
          xb_sel_o[o*IW +: IW]     <= cand[o*IW +: IW];
        end
      end
      for (int i = 0; i < P; i++)
        xb_flit_o[i*FW +: FW] <= bus_in[i] ? link_flit_i[i*FW +: FW]
                                           : buf_flit_i[i*FW +: FW];
    end
  end
endmodule

// File: rtl/bbu_checker.sv
module bbu_checker #(
  parameter int P  = 5,
  parameter int IW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            pause_i,
  input logic [1:0]      dir_i,
  input logic [P-1:0]    buf_valid_i,
  input logic [P-1:0]    buf_pop_o,
  input logic [P*IW-1:0] xb_sel_o,
  input logic            starve_o
);
  logic       pause_d;
  logic [1:0] dir_d;
  int         dst_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pause_d <= 1'b0;
      dir_d   <= '0;
    end else begin
      pause_d <= pause_i;
      dir_d   <= dir_i;
    end
  end

  // destination is the opposite port of the same axis
  assign dst_d = int'(dir_d ^ 2'b01);

  assert_bus_select_R1: assert property (@(posedge clk) disable iff (rst)
    pause_d |-> (xb_sel_o[dst_d*IW +: IW] == IW'(dir_d)));

  assert_claimed_input_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    pause_i |-> !buf_pop_o[dir_i]);

  assert_release_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!pause_i && pause_d) |-> !buf_pop_o[dir_d]);

  assert_token_needs_wait_R8: assert property (@(posedge clk) disable iff (rst)
    starve_o |-> $past(|buf_valid_i));

  assert_forward_clears_R9: assert property (@(posedge clk) disable iff (rst)
    $past(|buf_pop_o) |-> !starve_o);
endmodule

bind bus_bypass_unit bbu_checker #(.P(P), .IW(IW)) u_bbu_checker (
  .clk(clk), .rst(rst), .pause_i(pause_i), .dir_i(dir_i),
  .buf_valid_i(buf_valid_i), .buf_pop_o(buf_pop_o),
  .xb_sel_o(xb_sel_o), .starve_o(starve_o)
);

// File: tb/test_bus_bypass_unit.sv
`timescale 1ns/1ps
module test_bus_bypass_unit;
  localparam int P  = 5;
  localparam int FW = 16;
  localparam int IW = 3;

  logic            clk = 1'b0;
  logic            rst;
  logic            pause_i;
  logic [1:0]      dir_i;
  logic [P-1:0]    link_valid_i;
  logic [P*FW-1:0] link_flit_i;
  logic [P-1:0]    buf_valid_i;
  logic [P*FW-1:0] buf_flit_i;
  logic [P-1:0]    sa_gnt_i;
  logic [P*IW-1:0] sa_sel_i;
  logic [P-1:0]    buf_pop_o;
  logic [P-1:0]    xb_vld_o;
  logic [P*IW-1:0] xb_sel_o;
  logic [P*FW-1:0] xb_flit_o;
  logic            starve_o;

  always #2.5 clk = ~clk;

  bus_bypass_unit #(.P(P), .FW(FW)) i_bus_bypass_unit (.*);

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  // opposite-port map for direction codes 0..3 (source index equals the code)
  function automatic int dst_of(input int d);
    case (d)
      0: return 1;
      1: return 0;
      2: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic logic [FW-1:0] bflit(input int i);
    return 16'hC000 | 16'(i);
  endfunction
  function automatic logic [FW-1:0] lflit(input int i);
    return 16'h0100 | 16'(i);
  endfunction

  task automatic idle();
    pause_i = 0; dir_i = 0; link_valid_i = '0; link_flit_i = '0;
    buf_valid_i = '0; buf_flit_i = '0; sa_gnt_i = '0; sa_sel_i = '0;
  endtask

  typedef struct packed {
    logic       pz;
    logic [1:0] dr;
    logic [2:0] so;
    logic [2:0] si;
    logic [4:0] ev;
    logic [4:0] ep;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{1'b0, 2'd0, 3'd1, 3'd4, 5'b00010, 5'b10000},
    '{1'b0, 2'd0, 3'd3, 3'd2, 5'b01000, 5'b00100},
    '{1'b1, 2'd0, 3'd3, 3'd4, 5'b01010, 5'b10000},
    '{1'b0, 2'd0, 3'd7, 3'd0, 5'b00000, 5'b00000},
    '{1'b1, 2'd2, 3'd3, 3'd4, 5'b01000, 5'b00000},
    '{1'b0, 2'd0, 3'd7, 3'd0, 5'b00000, 5'b00000},
    '{1'b1, 2'd1, 3'd2, 3'd1, 5'b00001, 5'b00000},
    '{1'b0, 2'd0, 3'd7, 3'd0, 5'b00000, 5'b00000},
    '{1'b1, 2'd3, 3'd0, 3'd4, 5'b00101, 5'b10000},
    '{1'b0, 2'd0, 3'd2, 3'd4, 5'b00000, 5'b00000},
    '{1'b0, 2'd0, 3'd2, 3'd4, 5'b00100, 5'b10000}
  };
  localparam string TAG [NV] = '{"R2", "R2", "R4", "R2", "R3", "R2",
                                 "R3", "R2", "R1", "R7", "R2"};

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) cyc();
    rst = 0;
    #1;
    // R10 reset state
    chk("R10 xb_vld", 32'(xb_vld_o), 0);
    chk("R10 pop", 32'(buf_pop_o), 0);
    chk("R10 starve", 32'(starve_o), 0);
    cyc();
    chk("R10 xb_vld idle", 32'(xb_vld_o), 0);

    // table of single-flit stimulus
    for (int k = 0; k < NV; k++) begin
      pause_i = VT[k].pz;
      dir_i   = VT[k].dr;
      link_valid_i = '1;
      buf_valid_i  = '1;
      for (int i = 0; i < P; i++) begin
        link_flit_i[i*FW +: FW] = lflit(i);
        buf_flit_i[i*FW +: FW]  = bflit(i);
        sa_sel_i[i*IW +: IW]    = VT[k].si;
      end
      sa_gnt_i = (VT[k].so < 3'd5) ? (5'b1 << VT[k].so) : '0;
      #1;
      chk({TAG[k], " pop"}, 32'(buf_pop_o), 32'(VT[k].ep));
      cyc();
      chk({TAG[k], " vld"}, 32'(xb_vld_o), 32'(VT[k].ev));
      for (int o = 0; o < P; o++) begin
        if (VT[k].ev[o]) begin
          logic bus;
          logic [IW-1:0] es;
          logic [IW-1:0] as;
          bus = VT[k].pz && (o == dst_of(int'(VT[k].dr)));
          es  = bus ? IW'(VT[k].dr) : VT[k].si;
          as  = xb_sel_o[o*IW +: IW];
          chk({TAG[k], " sel"}, 32'(as), 32'(es));
          chk({TAG[k], " flit"}, 32'(xb_flit_o[as*FW +: FW]),
              32'(bus ? lflit(int'(es)) : bflit(int'(es))));
        end
      end
    end

    // wormhole packet interrupted by a bus claim on its output: R5 R6 R7
    idle();
    repeat (3) cyc();
    begin
      logic [FW-1:0] pkt [4];
      logic          pz  [9];
      logic          ev  [9];
      logic [IW-1:0] es  [9];
      logic [FW-1:0] ef  [9];
      int idx;
      int got;
      pkt = '{16'h8001, 16'h0002, 16'h0003, 16'h4004};
      pz  = '{0, 0, 1, 1, 1, 0, 0, 0, 0};
      ev  = '{1, 1, 1, 1, 1, 0, 1, 1, 0};
      es  = '{4, 4, 0, 0, 0, 0, 4, 4, 0};
      ef  = '{16'h8001, 16'h0002, 16'h0100, 16'h0100, 16'h0100, 0,
              16'h0003, 16'h4004, 0};
      idx = 0;
      got = 0;
      for (int c = 0; c < 9; c++) begin
        logic popped;
        pause_i = pz[c];
        dir_i   = 2'd0;
        link_valid_i = 5'b00001;
        link_flit_i[0 +: FW] = 16'h0100;
        buf_valid_i = (idx < 4) ? 5'b10000 : '0;
        buf_flit_i[4*FW +: FW] = (idx < 4) ? pkt[idx] : '0;
        sa_gnt_i = (c == 0) ? 5'b00010 : '0;
        sa_sel_i[1*IW +: IW] = 3'd4;
        #1;
        popped = buf_pop_o[4];
        if (c >= 2 && c <= 5) chk("R3 frozen pop", 32'(popped), 0);
        cyc();
        if (popped) idx++;
        if (c == 5) chk("R7 release idle", 32'(xb_vld_o[1]), 0);
        else if (c == 1) chk("R5 body without grant", 32'(xb_vld_o[1]), 1);
        else chk("R6 vld", 32'(xb_vld_o[1]), 32'(ev[c]));
        if (ev[c]) begin
          logic [IW-1:0] as;
          as = xb_sel_o[1*IW +: IW];
          chk("R6 sel", 32'(as), 32'(es[c]));
          chk("R6 flit", 32'(xb_flit_o[as*FW +: FW]), 32'(ef[c]));
          if (as == 3'd4) got++;
        end
      end
      chk("R6 flits delivered", 32'(got), 4);
      chk("R6 buffer drained", 32'(idx), 4);
    end

    // starvation token: R8 R9
    idle();
    repeat (3) cyc();
    buf_valid_i = 5'b10000;
    buf_flit_i[4*FW +: FW] = bflit(4);
    for (int k = 0; k < 4; k++) begin
      pause_i = 1; dir_i = 2'd2;
      cyc();
      chk("R8 token after start", 32'(starve_o), (k == 3) ? 1 : 0);
      pause_i = 0;
      cyc();
    end
    chk("R8 token held", 32'(starve_o), 1);
    buf_valid_i = '0;
    cyc();
    chk("R9 cleared by empty", 32'(starve_o), 0);
    buf_valid_i = 5'b10000;
    pause_i = 1;
    cyc();
    chk("R9 count restarted", 32'(starve_o), 0);
    pause_i = 0;
    cyc();
    for (int k = 0; k < 3; k++) begin
      pause_i = 1;
      cyc();
      pause_i = 0;
      cyc();
    end
    chk("R8 token again", 32'(starve_o), 1);
    sa_gnt_i = 5'b01000;
    sa_sel_i[3*IW +: IW] = 3'd4;
    #1;
    chk("R9 forward pop", 32'(buf_pop_o), 32'(5'b10000));
    cyc();
    chk("R9 cleared by forward", 32'(starve_o), 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule